// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects eight edge-triggered interrupt requests and presents one interrupt line to a processor. When the processor acknowledges, the block answers with an 8-bit vector number. Resolution uses a fixed priority, and the block remembers which requests are being serviced. A request of equal or lower priority than one in service is not forwarded until software retires the serviced one with an end-of-interrupt command.

Software writes bytes through a two-register port. A select bit chooses the command register or the data register. A restart command begins a strict setup sequence, and what each following data byte means depends on its position in that sequence. The first byte is the vector base. The second is the cascade wiring word: a slave bitmask when the block is a master, or an identity number when it is a slave. The third is the processor-mode word. Once the sequence is complete, data bytes load the mask. The cascade word is the only role information the block holds, and it is presented unchanged to surrounding logic. Before any setup, the block runs with base 8 and every input enabled.

Top module: `intc8_top`

## Requirements
- R1: After reset the vector base is 8 and the mask is 0x00. The setup sequence counts as complete, so input n is delivered as vector 8+n. irq_out, vec_valid, casc_cfg and cpu_mode are all 0.
- R2: Writing 0x11 to the command register (wr_sel=0) starts setup. The next three data writes (wr_sel=1) are the base, the cascade word and the mode word, in that order. irq_out is held low until the third of these has been written. A 0x11 written partway through starts the sequence over.
- R3: The delivered vector is (base + n) modulo 256 for input n. With base 32, input 3 gives 35. With base 0xFC, input 7 gives 0x03.
- R4: casc_cfg shows the cascade word exactly as written (0x04 for a master with a slave on input 2, 0x02 for slave identity 2). cpu_mode shows bit 0 of the mode word.
- R5: After setup, each data write loads the mask. A 1 in bit n blocks input n and a 0 enables it. A masked request stays pending and is delivered once its mask bit is cleared.
- R6: A rising edge on req_in[n] makes input n pending. A level held high after acknowledge does not request again.
- R7: Priority is fixed, with input 0 highest and input 7 lowest. When several requests are pending, the lowest index is delivered first.
- R8: ack_in sampled high while irq_out is high moves the winning input from pending to in-service. The next cycle then shows vec_valid high for one cycle, together with vec_out.
- R9: irq_out is high only when an enabled pending input has higher priority than every in-service input. A higher-priority request can therefore nest, while equal or lower ones wait.
- R10: Writing 0x20 to the command register clears only the highest-priority in-service bit. Other command values, apart from 0x11, have no effect.
- R11: Writing 0x11 clears the mask, all pending requests and all in-service bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command register, 1 the data register |
| wr_data | input | 8 | Byte written |
| req_in | input | 8 | Edge-triggered interrupt requests, bit 0 highest priority |
| ack_in | input | 1 | Processor acknowledge, one cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | vec_out is valid this cycle |
| vec_out | output | 8 | Vector of the acknowledged input |
| casc_cfg | output | 8 | Stored cascade word |
| cpu_mode | output | 1 | Stored processor-mode bit |

## Verification
A stuck or wrong in-service bit shows up at irq_out on the very next cycle after a request arrives: a new request of equal priority either raises the line when it should not, or a later request stays silent. An end-of-interrupt that clears the wrong bit is exposed right after the EOI write, because a still-pending request is then released, or stays blocked, against expectation. A setup sequence that has slipped by one position shows up at the first acknowledge as a wrong vector, or as a wrong casc_cfg value once setup completes.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  typedef enum logic [1:0] {
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_RUN
  } seq_st_e;

  localparam logic [7:0] CMD_RESTART = 8'h11;
  localparam logic [7:0] CMD_EOI     = 8'h20;
  localparam logic [7:0] BASE_AT_RST = 8'h08;
endpackage

// File: rtl/intc8_cfg.sv
module intc8_cfg
  import intc8_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   base_q,
  output logic [DW-1:0]   casc_q,
  output logic            mode_q,
  output logic [NREQ-1:0] mask_q,
  output logic            init_done,
  output logic            init_cmd,
  output logic            eoi_cmd
);
  seq_st_e st_q;
  logic    data_wr;

  assign data_wr   = wr_en & wr_sel;
  assign init_cmd  = wr_en & ~wr_sel & (wr_data == CMD_RESTART);
  assign init_done = (st_q == SEQ_RUN);
  assign eoi_cmd   = wr_en & ~wr_sel & (wr_data == CMD_EOI) & init_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_RUN;
      base_q <= BASE_AT_RST;
      casc_q <= '0;
      mode_q <= 1'b0;
      mask_q <= '0;
    end else if (init_cmd) begin
      st_q   <= SEQ_BASE;
      mask_q <= '0;
    end else if (data_wr) begin
      unique case (st_q)
        SEQ_BASE: begin base_q <= wr_data;    st_q <= SEQ_CASC; end
        SEQ_CASC: begin casc_q <= wr_data;    st_q <= SEQ_MODE; end
        SEQ_MODE: begin mode_q <= wr_data[0]; st_q <= SEQ_RUN;  end
        default:        mask_q <= wr_data[NREQ-1:0];
      endcase
    end
  end
endmodule

// File: rtl/intc8_reqs.sv
module intc8_reqs #(
  parameter int unsigned NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_in,
  input  logic [NREQ-1:0] take,
  input  logic            clr_all,
  output logic [NREQ-1:0] pend_q
);
  logic [NREQ-1:0] prev_q;
  logic [NREQ-1:0] rise;

  assign rise = req_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req_in;
      if (clr_all) pend_q <= '0;
      else         pend_q <= (pend_q & ~take) | rise;
    end
  end
endmodule

// File: rtl/intc8_isr.sv
module intc8_isr #(
  parameter int unsigned NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] set,
  input  logic            eoi,
  input  logic            clr_all,
  output logic [NREQ-1:0] isr_q
);
  logic [NREQ-1:0] top_bit;

  // isolate lowest-index (highest priority) set bit
  assign top_bit = isr_q & (~isr_q + NREQ'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       isr_q <= '0;
    else if (clr_all) isr_q <= '0;
    else              isr_q <= (isr_q & ~(eoi ? top_bit : '0)) | set;
  end
endmodule

// File: rtl/intc8_prio.sv
module intc8_prio #(
  parameter int unsigned NREQ = 8,
  localparam int unsigned IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0] pend,
  input  logic [NREQ-1:0] mask,
  input  logic [NREQ-1:0] isr,
  output logic            win_valid,
  output logic [IW-1:0]   win_idx,
  output logic [NREQ-1:0] win_onehot
);
  function automatic logic [IW:0] first_set(input logic [NREQ-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  logic [IW:0] p_pick;
  logic [IW:0] s_pick;

  assign p_pick     = first_set(pend & ~mask);
  assign s_pick     = first_set(isr);
  assign win_idx    = p_pick[IW-1:0];
  assign win_valid  = p_pick[IW] & (~s_pick[IW] | (p_pick[IW-1:0] < s_pick[IW-1:0]));
  assign win_onehot = win_valid ? (NREQ'(1) << win_idx) : '0;
endmodule

// File: rtl/intc8_top.sv
module intc8_top
  import intc8_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREQ = 8,
  localparam int unsigned IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [NREQ-1:0] req_in,
  input  logic            ack_in,
  output logic            irq_out,
  output logic            vec_valid,
  output logic [DW-1:0]   vec_out,
  output logic [DW-1:0]   casc_cfg,
  output logic            cpu_mode
);
  logic [DW-1:0]   base_q;
  logic [NREQ-1:0] mask_q;
  logic [NREQ-1:0] pend_q;
  logic [NREQ-1:0] isr_q;
  logic [NREQ-1:0] win_onehot;
  logic [NREQ-1:0] grant;
  logic [IW-1:0]   win_idx;
  logic            win_valid;
  logic            init_done;
  logic            init_cmd;
  logic            eoi_cmd;
  logic            ack_fire;

  function automatic logic [DW-1:0] vec_of(input logic [DW-1:0] b, input logic [IW-1:0] i);
    return b + DW'(i);
  endfunction

  intc8_cfg #(.DW(DW), .NREQ(NREQ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .base_q(base_q), .casc_q(casc_cfg), .mode_q(cpu_mode), .mask_q(mask_q),
    .init_done(init_done), .init_cmd(init_cmd), .eoi_cmd(eoi_cmd)
  );

  intc8_reqs #(.NREQ(NREQ)) u_reqs (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .take(grant),
    .clr_all(init_cmd), .pend_q(pend_q)
  );

  intc8_isr #(.NREQ(NREQ)) u_isr (
    .clk(clk), .rst_n(rst_n), .set(grant), .eoi(eoi_cmd),
    .clr_all(init_cmd), .isr_q(isr_q)
  );

  intc8_prio #(.NREQ(NREQ)) u_prio (
    .pend(pend_q), .mask(mask_q), .isr(isr_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_onehot(win_onehot)
  );

  assign irq_out  = init_done & win_valid;
  assign ack_fire = ack_in & irq_out;
  assign grant    = ack_fire ? win_onehot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= ack_fire;
      if (ack_fire) vec_out <= vec_of(base_q, win_idx);
    end
  end
endmodule

// File: rtl/intc8_chk.sv
module intc8_chk #(
  parameter int unsigned NREQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_out,
  input logic            vec_valid,
  input logic            init_done,
  input logic            init_cmd,
  input logic            eoi_cmd,
  input logic            ack_fire,
  input logic [NREQ-1:0] isr_q,
  input logic [NREQ-1:0] pend_q,
  input logic [NREQ-1:0] mask_q
);
  // R2
  irq_quiet_in_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !irq_out);

  // R8
  vec_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_fire));

  // R8
  ack_adds_one_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !eoi_cmd && !init_cmd) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  // R10
  eoi_drops_one_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !ack_fire && (isr_q != '0)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R11
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (!init_done && isr_q == '0 && pend_q == '0 && mask_q == '0));

  // R5
  irq_needs_enabled_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((pend_q & ~mask_q) != '0));
endmodule

bind intc8_top intc8_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .vec_valid(vec_valid),
  .init_done(init_done), .init_cmd(init_cmd), .eoi_cmd(eoi_cmd),
  .ack_fire(ack_fire), .isr_q(isr_q), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/sim_intc8_top.sv
`timescale 1ns/1ps
module sim_intc8_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] req_in = '0;
  logic       ack_in = 1'b0;
  logic       irq_out;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic [7:0] casc_cfg;
  logic       cpu_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc8_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_in(req_in), .ack_in(ack_in), .irq_out(irq_out), .vec_valid(vec_valid),
    .vec_out(vec_out), .casc_cfg(casc_cfg), .cpu_mode(cpu_mode)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic eoi();
    wr(1'b0, 8'h20);
  endtask

  task automatic pulse(input logic [7:0] bits);
    req_in = req_in | bits;
    @(negedge clk);
    req_in = req_in & ~bits;
  endtask

  task automatic take_vec(input string tag, input logic [7:0] exp);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk({tag, " vec_valid"}, {7'd0, vec_valid}, 8'h01);
    chk({tag, " vector"}, vec_out, exp);
    @(negedge clk);
    chk({tag, " vec_valid one cycle"}, {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic setup(input logic [7:0] base, input logic [7:0] casc);
    wr(1'b0, 8'h11);
    wr(1'b1, base);
    wr(1'b1, casc);
    wr(1'b1, 8'h01);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'h00);
    chk("R1 casc_cfg after reset", casc_cfg, 8'h00);
    chk("R1 cpu_mode after reset", {7'd0, cpu_mode}, 8'h00);
    pulse(8'h01);
    chk("R1 default irq", {7'd0, irq_out}, 8'h01);
    take_vec("R1 default base", 8'h08);
    eoi();
  endtask

  task automatic t_master_setup();
    wr(1'b0, 8'h11);
    pulse(8'h08);
    chk("R2 irq held in setup", {7'd0, irq_out}, 8'h00);
    wr(1'b1, 8'd32);
    wr(1'b1, 8'h04);
    chk("R2 irq held before mode word", {7'd0, irq_out}, 8'h00);
    wr(1'b1, 8'h01);
    chk("R2 irq after setup", {7'd0, irq_out}, 8'h01);
    take_vec("R3 base 32 input 3", 8'd35);
    chk("R4 master casc word", casc_cfg, 8'h04);
    chk("R4 mode bit", {7'd0, cpu_mode}, 8'h01);
    eoi();
  endtask

  task automatic t_mask();
    wr(1'b1, 8'h08);
    pulse(8'h08);
    chk("R5 masked input silent", {7'd0, irq_out}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R5 released after unmask", {7'd0, irq_out}, 8'h01);
    take_vec("R5 unmasked vector", 8'd35);
    eoi();
  endtask

  task automatic t_edge();
    req_in[5] = 1'b1;
    @(negedge clk);
    take_vec("R6 held input", 8'd37);
    eoi();
    @(negedge clk);
    chk("R6 held level no re-request", {7'd0, irq_out}, 8'h00);
    req_in[5] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_prio();
    pulse(8'h42);
    take_vec("R7 lowest index first", 8'd33);
    chk("R9 lower blocked", {7'd0, irq_out}, 8'h00);
    eoi();
    chk("R9 lower released after EOI", {7'd0, irq_out}, 8'h01);
    take_vec("R7 second", 8'd38);
    eoi();
  endtask

  task automatic t_nest();
    pulse(8'h10);
    take_vec("R8 input 4", 8'd36);
    pulse(8'h10);
    chk("R9 equal blocked", {7'd0, irq_out}, 8'h00);
    pulse(8'h04);
    chk("R9 higher nests", {7'd0, irq_out}, 8'h01);
    take_vec("R9 nested vector", 8'd34);
    eoi();
    chk("R10 EOI cleared top bit only", {7'd0, irq_out}, 8'h00);
    eoi();
    chk("R10 second EOI releases", {7'd0, irq_out}, 8'h01);
    take_vec("R10 repeat input 4", 8'd36);
    eoi();
    chk("R10 idle after EOIs", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_ignored();
    pulse(8'h02);
    take_vec("R10 setup", 8'd33);
    wr(1'b0, 8'h55);
    pulse(8'h02);
    chk("R10 other command ignored", {7'd0, irq_out}, 8'h00);
    eoi();
    chk("R10 EOI after ignored", {7'd0, irq_out}, 8'h01);
    take_vec("R10 input 1 again", 8'd33);
    eoi();
  endtask

  task automatic t_restart();
    wr(1'b1, 8'h80);
    pulse(8'h40);
    take_vec("R11 pre-restart", 8'd38);
    pulse(8'h80);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'd50);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'd40);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h01);
    chk("R11 pending cleared", {7'd0, irq_out}, 8'h00);
    chk("R4 slave identity", casc_cfg, 8'h02);
    pulse(8'h80);
    chk("R11 mask and isr cleared", {7'd0, irq_out}, 8'h01);
    take_vec("R2 mid-sequence restart base 40", 8'd47);
    eoi();
  endtask

  task automatic t_wrap();
    setup(8'hFC, 8'h00);
    pulse(8'h80);
    take_vec("R3 wrap input 7", 8'h03);
    pulse(8'h01);
    take_vec("R3 base input 0", 8'hFC);
    eoi();
    eoi();
    chk("R10 all retired", {7'd0, irq_out}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_master_setup();
    t_mask();
    t_edge();
    t_prio();
    t_nest();
    t_ignored();
    t_restart();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule